// File: doc/BRIEF.md
# Adder-Tree Population Counter

This block takes a 31-bit word and reports how many of its bits are set, as a 5-bit count from 0 to 31. The count is formed by an explicit network of small adders rather than a behavioural loop. Full adders at the leaves turn each group of three input bits into a 2-bit partial count. The input bits that no leaf consumes are not handled by extra adders. Each one enters an upper adder as its carry-in, so exactly 31 inputs fill a 5-bit result.

Two tree shapes can be chosen at compile time, and both give the same count for every input. The pairwise shape adds partial counts two at a time, with one raw bit per adder as carry-in: four 3-bit sums, then two 4-bit sums, then the 5-bit total. The compression shape reduces ten leaf counts and the one spare bit with rows of full adders, three operands to two, until two vectors remain. One final ripple adder then sums those two vectors. A second compile-time switch places a register on the 5-bit result. That register has a synchronous active-high reset. Without the register the block is purely combinational.

Top module: `popcount31`

## Requirements
- R1: For every 31-bit input, the count equals the number of set bits in the input, and bit 0 of the count equals the XOR of all input bits.
- R2: An input of all zeros gives a count of 0.
- R3: An input of all ones gives a count of 31, with no wrap to a smaller value.
- R4: An input with exactly one bit set gives 1, and an input with exactly one bit clear gives 30, for each of the 31 bit positions. This exercises every leaf and every carry-in point.
- R5: The pairwise shape (USE_CSA = 0) and the compression shape (USE_CSA = 1) give identical counts for the same input.
- R6: With REG_OUT = 0, count_out follows bits_in within the same cycle, with no clock edge needed.
- R7: With REG_OUT = 1, count_out shows the count of the input sampled at a rising clk edge, from that edge until the next one.
- R8: With REG_OUT = 1, rst high at a rising edge sets count_out to 0 and keeps it at 0 while rst stays high, whatever bits_in is. The first edge with rst low loads the current count.
- R9: The alternating patterns give 15 when only the odd bit positions 1 to 29 are set, and 16 when only the even bit positions 0 to 30 are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| bits_in | input | 31 | Word whose set bits are counted |
| count_out | output | 5 | Number of set bits, registered or combinational per REG_OUT |

## Verification
A fault inside the tree shows up as a wrong count. Examples are a miswired leaf, a carry-in taken from the wrong input bit, or a carry dropped in a compression row. The error appears in the same cycle in the combinational build and one edge later in the registered build. It shows only for inputs that drive the faulty node, so every single-bit and single-hole pattern is swept, and each position reaches its own leaf or carry-in. The swept and random inputs are fed to both shapes at once, so a fault in either one shows as a mismatch with the reference and with the other shape. A wrong register or reset shows as a count that changes before the clock edge or a nonzero value while reset is held.

// File: rtl/popc_pkg.sv
package popc_pkg;

    // Default word width: 2**k - 1 bits fill a pairwise tree exactly.
    localparam int unsigned POPC_IN_W = 31;

    // Width needed to hold a count of 0..n.
    function automatic int unsigned popc_cnt_w(input int unsigned n);
        return $clog2(n + 1);
    endfunction

    // Operand count after one row of three-to-two compression.
    function automatic int unsigned csa_next(input int unsigned n);
        return (n / 3) * 2 + (n % 3);
    endfunction

    // Operand count after s rows of compression.
    function automatic int unsigned csa_after(input int unsigned n, input int unsigned s);
        int unsigned m;
        m = n;
        for (int unsigned i = 0; i < s; i++) begin
            m = csa_next(m);
        end
        return m;
    endfunction

    // Rows needed to bring n operands down to two.
    function automatic int unsigned csa_stages(input int unsigned n);
        int unsigned m;
        int unsigned k;
        m = n;
        k = 0;
        while (m > 2) begin
            m = csa_next(m);
            k++;
        end
        return k;
    endfunction

endpackage

// File: rtl/popc_fa3.sv
// Three-input full adder: the count of ones among a, b, c as a 2-bit value.
module popc_fa3 (
    input  logic       a,
    input  logic       b,
    input  logic       c,
    output logic [1:0] s
);
    always_comb begin
        s[0] = a ^ b ^ c;
        s[1] = (a & b) | (a & c) | (b & c);
    end
endmodule

// File: rtl/popc_add.sv
// Ripple adder of two W-bit operands plus a one-bit carry-in, built from full adders.
module popc_add #(
    parameter int unsigned W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W:0]   sum
);
    logic [W:0] cy;

    assign cy[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] r;
        popc_fa3 u_fa (
            .a (a[i]),
            .b (b[i]),
            .c (cy[i]),
            .s (r)
        );
        assign sum[i]   = r[0];
        assign cy[i+1]  = r[1];
    end

    assign sum[W] = cy[W];
endmodule

// File: rtl/popc_tree_plain.sv
// Pairwise tree. Leaves take bits in threes; every adder above the leaves
// takes one further raw bit as carry-in, so IN_W must be 2**k - 1 (k >= 2).
module popc_tree_plain #(
    parameter  int unsigned IN_W  = 31,
    localparam int unsigned DEPTH = $clog2(IN_W + 1) - 2,
    localparam int unsigned NLEAF = 1 << DEPTH,
    localparam int unsigned CNT_W = DEPTH + 2
) (
    input  logic [IN_W-1:0]  bits,
    output logic [CNT_W-1:0] count
);
    for (genvar k = 0; k <= DEPTH; k++) begin : g_lvl
        localparam int unsigned NODES = NLEAF >> k;
        logic [k+1:0] v [NODES];

        if (k == 0) begin : g_leaf
            for (genvar i = 0; i < NODES; i++) begin : g_fa
                popc_fa3 u_fa (
                    .a (bits[3*i]),
                    .b (bits[3*i+1]),
                    .c (bits[3*i+2]),
                    .s (v[i])
                );
            end
        end else begin : g_sum
            // Raw bits after the leaves are handed out level by level.
            localparam int unsigned CIN_BASE = 4 * NLEAF - (NLEAF >> (k - 1));
            for (genvar i = 0; i < NODES; i++) begin : g_add
                popc_add #(.W(k + 1)) u_add (
                    .a   (g_lvl[k-1].v[2*i]),
                    .b   (g_lvl[k-1].v[2*i+1]),
                    .cin (bits[CIN_BASE+i]),
                    .sum (v[i])
                );
            end
        end
    end

    assign count = g_lvl[DEPTH].v[0];
endmodule

// File: rtl/popc_tree_csa.sv
// Compression tree. Leaf full adders make 2-bit counts; rows of bitwise full
// adders turn three operands into two (mod 2**CNT_W) until two remain, then
// one ripple adder forms the total.
module popc_tree_csa
    import popc_pkg::*;
#(
    parameter  int unsigned IN_W  = 31,
    localparam int unsigned CNT_W = popc_cnt_w(IN_W),
    localparam int unsigned NFA   = IN_W / 3,
    localparam int unsigned NREM  = IN_W % 3,
    localparam int unsigned NOP   = NFA + NREM,
    localparam int unsigned NSTG  = csa_stages(NOP)
) (
    input  logic [IN_W-1:0]  bits,
    output logic [CNT_W-1:0] count
);
    for (genvar s = 0; s <= NSTG; s++) begin : g_stg
        localparam int unsigned N = csa_after(NOP, s);
        logic [CNT_W-1:0] op [N];

        if (s == 0) begin : g_leaf
            for (genvar i = 0; i < NFA; i++) begin : g_fa
                logic [1:0] pc;
                popc_fa3 u_fa (
                    .a (bits[3*i]),
                    .b (bits[3*i+1]),
                    .c (bits[3*i+2]),
                    .s (pc)
                );
                assign op[i] = CNT_W'(pc);
            end
            for (genvar r = 0; r < NREM; r++) begin : g_spare
                assign op[NFA+r] = CNT_W'(bits[3*NFA+r]);
            end
        end else begin : g_row
            localparam int unsigned NP = csa_after(NOP, s - 1);
            localparam int unsigned NT = NP / 3;
            for (genvar t = 0; t < NT; t++) begin : g_csa
                logic [CNT_W-1:0] sv;
                logic [CNT_W-1:0] cv;
                for (genvar b = 0; b < CNT_W - 1; b++) begin : g_col
                    logic [1:0] r;
                    popc_fa3 u_fa (
                        .a (g_stg[s-1].op[3*t][b]),
                        .b (g_stg[s-1].op[3*t+1][b]),
                        .c (g_stg[s-1].op[3*t+2][b]),
                        .s (r)
                    );
                    assign sv[b]   = r[0];
                    assign cv[b+1] = r[1];
                end
                // Top column: its carry would leave the count width, so only the sum is kept.
                assign sv[CNT_W-1] = g_stg[s-1].op[3*t][CNT_W-1]
                                   ^ g_stg[s-1].op[3*t+1][CNT_W-1]
                                   ^ g_stg[s-1].op[3*t+2][CNT_W-1];
                assign cv[0]    = 1'b0;
                assign op[2*t]   = sv;
                assign op[2*t+1] = cv;
            end
            for (genvar r = 0; r < NP % 3; r++) begin : g_pass
                assign op[2*NT+r] = g_stg[s-1].op[3*NT+r];
            end
        end
    end

    logic [CNT_W-1:0] fa;
    logic [CNT_W-1:0] fb;
    logic [CNT_W-1:0] lo;

    assign fa = g_stg[NSTG].op[0];
    assign fb = g_stg[NSTG].op[1];

    popc_add #(.W(CNT_W - 1)) u_final (
        .a   (fa[CNT_W-2:0]),
        .b   (fb[CNT_W-2:0]),
        .cin (1'b0),
        .sum (lo)
    );

    assign count = {fa[CNT_W-1] ^ fb[CNT_W-1] ^ lo[CNT_W-1], lo[CNT_W-2:0]};
endmodule

// File: rtl/popcount31.sv
// Population counter top: tree shape and output register chosen at compile time.
module popcount31
    import popc_pkg::*;
#(
    parameter  int unsigned IN_W    = POPC_IN_W,
    parameter  bit          USE_CSA = 1'b0,
    parameter  bit          REG_OUT = 1'b1,
    localparam int unsigned CNT_W   = popc_cnt_w(IN_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  bits_in,
    output logic [CNT_W-1:0] count_out
);
    logic [CNT_W-1:0] tree_cnt;

    if (USE_CSA) begin : g_csa
        popc_tree_csa #(.IN_W(IN_W)) u_tree (
            .bits  (bits_in),
            .count (tree_cnt)
        );
    end else begin : g_plain
        popc_tree_plain #(.IN_W(IN_W)) u_tree (
            .bits  (bits_in),
            .count (tree_cnt)
        );
    end

    if (REG_OUT) begin : g_reg
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= tree_cnt;
            end
        end

        assign count_out = cnt_q;

        // R7: the registered count is the tree result of the previous edge.
        p_latency_r7: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (count_out == $past(tree_cnt)));
    end else begin : g_comb
        assign count_out = tree_cnt;
    end

    // R1: parity of the input shows in bit 0 of the count.
    p_parity_r1: assert property (@(posedge clk) disable iff (rst)
        tree_cnt[0] == (^bits_in));

    // R2: no set bit, zero count.
    p_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bits_in == '0) |-> (tree_cnt == '0));

    // R3: all bits set reaches the full width without wrapping.
    p_full_r3: assert property (@(posedge clk) disable iff (rst)
        (&bits_in) |-> (tree_cnt == CNT_W'(IN_W)));
endmodule

// File: tb/tb_popcount31.sv
module tb_popcount31;
    localparam int unsigned IN_W       = 31;
    localparam int unsigned CNT_W      = 5;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned N_RANDOM   = 10000;

    logic             clk;
    logic             rst;
    logic [IN_W-1:0]  stim;
    logic [CNT_W-1:0] c_pr, c_cr, c_pc, c_cc;

    int n_chk  = 0;
    int n_fail = 0;
    int prev   = 0;
    bit done   = 1'b0;

    popcount31 #(.USE_CSA(1'b0), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst(rst), .bits_in(stim), .count_out(c_pr));
    popcount31 #(.USE_CSA(1'b1), .REG_OUT(1'b1)) dut_csa_reg (
        .clk(clk), .rst(rst), .bits_in(stim), .count_out(c_cr));
    popcount31 #(.USE_CSA(1'b0), .REG_OUT(1'b0)) dut_plain_comb (
        .clk(clk), .rst(rst), .bits_in(stim), .count_out(c_pc));
    popcount31 #(.USE_CSA(1'b1), .REG_OUT(1'b0)) dut_csa_comb (
        .clk(clk), .rst(rst), .bits_in(stim), .count_out(c_cc));

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int ones(input logic [IN_W-1:0] v);
        int n = 0;
        for (int i = 0; i < IN_W; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Drive at the falling edge; combinational outputs checked before the next
    // rising edge (R6), registered outputs must still hold the old count (R7)
    // and show the new one just after the rising edge.
    task automatic apply(input logic [IN_W-1:0] v, input string req);
        int exp;
        exp = ones(v);
        @(negedge clk);
        stim = v;
        #1;
        chk({req, " R6 plain comb"}, int'(c_pc), exp);
        chk({req, " R6 csa comb"},   int'(c_cc), exp);
        chk({req, " R5 shapes agree"}, int'(c_pc), int'(c_cc));
        chk({req, " R7 hold before edge"}, int'(c_pr), prev);
        @(posedge clk);
        #1;
        chk({req, " R7 plain reg"}, int'(c_pr), exp);
        chk({req, " R7 csa reg"},   int'(c_cr), exp);
        prev = exp;
    endtask

    initial begin
        rst  = 1'b1;
        stim = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset state plain", int'(c_pr), 0);
        chk("R8 reset state csa",   int'(c_cr), 0);
        @(negedge clk);
        rst = 1'b0;

        apply('0, "R2");
        apply('1, "R3");

        for (int i = 0; i < IN_W; i++) begin
            apply(IN_W'(1) << i, "R4 single set");
            apply(~(IN_W'(1) << i), "R4 single clear");
        end

        apply(31'h2AAA_AAAA, "R9 odd bits");
        chk("R9 odd count", int'(c_pr), 15);
        apply(31'h5555_5555, "R9 even bits");
        chk("R9 even count", int'(c_pr), 16);

        // R8: reset held with all ones at the input keeps the register at zero.
        @(negedge clk);
        rst  = 1'b1;
        stim = '1;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            #1;
            chk("R8 held plain", int'(c_pr), 0);
            chk("R8 held csa",   int'(c_cr), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R8 release loads plain", int'(c_pr), 31);
        chk("R8 release loads csa",   int'(c_cr), 31);
        prev = 31;

        for (int n = 0; n < N_RANDOM; n++) begin
            apply(IN_W'($urandom()), "R1 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule